// File: doc/BRIEF.md
# Byte-Readable Counter with Timebase Select

This block is a 16-bit free-running up-counter that an 8-bit register bus accesses one byte at a time. A 3-bit select field in a mode register chooses what advances the counter. The choices are the system clock, the system clock divided by 4 or by 12, a single-cycle overflow pulse from a neighbouring timer, falling edges on an asynchronous count pin, and an asynchronous oscillator pin divided by 8. Every timebase is turned into a one-cycle count-enable pulse on the system clock, so the block has only one clock.

Software reads the 16-bit value low byte first. That read copies the high byte into a snapshot, so the high-byte read that follows returns a value that matches the low byte. When the count wraps from 0xFFFF to 0x0000, a sticky overflow flag is set. Only software can clear it. The flag drives an interrupt request through three enables. A run bit starts and stops counting, and an idle-stop bit can freeze counting while the CPU idle input is high.

Top module: `tbase_counter`

## Requirements
- R1: The reset is synchronous and active-low. After reset, the count is 0x0000, the snapshot is 0x00, the overflow flag, run bit, idle-stop bit and interrupt enable are 0, the select field is 000, and the interrupt request is low.
- R2: Bus address map, with `busRdData` driven combinationally from `busAddr`:
  - Address 0 is the count low byte.
  - Address 1 is the high byte. Writes go to the live high byte; reads return the snapshot.
  - Address 2 is the mode byte: bit 7 idle-stop, bits 3:1 timebase select, bit 0 overflow interrupt enable. Bits 6:4 read 0.
  - Address 3 is the control byte: bit 7 overflow flag, bit 6 run. Bits 5:0 read 0.
- R3: A read strobe at address 0 copies the current count high byte into the snapshot at that clock edge. Later reads of address 1 return that copy even after the live high byte has changed.
- R4: Read strobes never change the counting. While a read is in progress, the count advances exactly as it would without it.
- R5: Select 100 advances the count on every clock. Select 000 advances it once per 12 clocks, and select 001 once per 4 clocks. Both prescalers run freely from reset.
- R6: Select 010 advances the count once for each clock cycle in which `timerOvfPulse` is high.
- R7: Select 011 counts falling edges of `extCountIn` after a two-flop synchronizer. After an edge is accepted, edges detected in the next 3 clocks are discarded, so accepted edges are at least 4 clocks apart.
- R8: Select 101 advances the count once for every 8 rising edges of `extOscIn` after a two-flop synchronizer.
- R9: Select codes 110 and 111 never advance the count.
- R10: The count holds while the run bit is 0. It also holds when idle-stop is 1 and `cpuIdle` is high. When idle-stop is 0, counting continues while `cpuIdle` is high.
- R11: An advance from 0xFFFF to 0x0000 sets the overflow flag. Writing 0 to control bit 7 clears the flag, and writing 1 leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R12: `ovfIrq` is high exactly when the overflow flag, the mode interrupt-enable bit, `globalIntEn` and `moduleIntEn` are all 1.
- R13: A bus write to address 0 or 1 loads that byte and blocks the increment in that cycle. The other byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 2 | Register select |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (drives snapshot capture) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the addressed register |
| timerOvfPulse | input | 1 | Overflow pulse from another timer, synchronous |
| extCountIn | input | 1 | Asynchronous count pin, falling edges counted |
| extOscIn | input | 1 | Asynchronous oscillator pin |
| cpuIdle | input | 1 | CPU idle indication |
| globalIntEn | input | 1 | Global interrupt enable |
| moduleIntEn | input | 1 | Module interrupt enable |
| countValue | output | 16 | Live counter value |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is an overflow and a software flag clear in the same clock edge. With the system clock timebase, the count cannot be parked at 0xFFFF and then released at a chosen cycle. The bench therefore selects the external timer-pulse timebase and loads 0xFFFF byte by byte while the counter is frozen. It then raises `timerOvfPulse` in the same cycle as the clear write. The rate limit on the count pin is reached by toggling it every clock, so that most detected edges fall inside the hold-off window.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  typedef enum logic [2:0] {
    TB_DIV_SLOW = 3'b000,
    TB_DIV_FAST = 3'b001,
    TB_TMR_OVF  = 3'b010,
    TB_EXT_EDGE = 3'b011,
    TB_SYSCLK   = 3'b100,
    TB_OSC_DIV  = 3'b101,
    TB_RSVD_A   = 3'b110,
    TB_RSVD_B   = 3'b111
  } tbSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic wrLow;
    logic wrHigh;
    logic snapLoad;
    logic flagWr;
    logic flagWrVal;
  } ctlStrobes_t;
endpackage

// File: rtl/tbc_sync.sv
module tbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int OSC_DIV     = 8,
  parameter int ECI_GAP     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              timerOvfPulse,
  input  logic              extCountIn,
  input  logic              extOscIn,
  input  logic              cpuIdle,
  output ctlStrobes_t       strobes,
  output logic [2:0]        modeSel,
  output logic              idleStop,
  output logic              ovfIntEn,
  output logic              runEn
);
  localparam int SLOW_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam int FAST_W = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
  localparam int OSC_W  = (OSC_DIV  > 1) ? $clog2(OSC_DIV)  : 1;
  localparam int GAP_W  = (ECI_GAP  > 1) ? $clog2(ECI_GAP)  : 1;
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(DIV_SLOW - 1);
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(DIV_FAST - 1);
  localparam logic [OSC_W-1:0]  OSC_LAST  = OSC_W'(OSC_DIV - 1);
  localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(ECI_GAP - 1);

  // register writes
  logic wrMode, wrCtrl;
  assign wrMode = busWrEn && (busAddr == ADDR_MODE);
  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSel  <= 3'b000;
      idleStop <= 1'b0;
      ovfIntEn <= 1'b0;
      runEn    <= 1'b0;
    end else begin
      if (wrMode) begin
        idleStop <= busWrData[7];
        modeSel  <= busWrData[3:1];
        ovfIntEn <= busWrData[0];
      end
      if (wrCtrl) runEn <= busWrData[6];
    end
  end

  // free-running prescalers
  logic [SLOW_W-1:0] slowCnt;
  logic [FAST_W-1:0] fastCnt;
  logic slowTick, fastTick;
  assign slowTick = (slowCnt == SLOW_LAST);
  assign fastTick = (fastCnt == FAST_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowCnt <= '0;
      fastCnt <= '0;
    end else begin
      slowCnt <= slowTick ? '0 : slowCnt + 1'b1;
      fastCnt <= fastTick ? '0 : fastCnt + 1'b1;
    end
  end

  // external count pin: sync, falling edge, rate limit
  logic eciNow, eciPrev, eciFall, eciAccept;
  logic [GAP_W-1:0] eciGap;

  tbc_sync #(.STAGES(SYNC_STAGES)) i_eciSync (
    .clk(clk), .rstN(rstN), .din(extCountIn), .dout(eciNow)
  );

  assign eciFall   = eciPrev && !eciNow;
  assign eciAccept = eciFall && (eciGap == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eciPrev <= 1'b0;
      eciGap  <= '0;
    end else begin
      eciPrev <= eciNow;
      if (eciAccept)        eciGap <= GAP_LOAD;
      else if (eciGap != '0) eciGap <= eciGap - 1'b1;
    end
  end

  // external oscillator: sync, rising edge, divide
  logic oscNow, oscPrev, oscRise, oscTick;
  logic [OSC_W-1:0] oscCnt;

  tbc_sync #(.STAGES(SYNC_STAGES)) i_oscSync (
    .clk(clk), .rstN(rstN), .din(extOscIn), .dout(oscNow)
  );

  assign oscRise = oscNow && !oscPrev;
  assign oscTick = oscRise && (oscCnt == OSC_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscPrev <= 1'b0;
      oscCnt  <= '0;
    end else begin
      oscPrev <= oscNow;
      if (oscRise) oscCnt <= (oscCnt == OSC_LAST) ? '0 : oscCnt + 1'b1;
    end
  end

  // timebase mux
  logic tbTick;
  always_comb begin
    unique case (tbSel_e'(modeSel))
      TB_DIV_SLOW: tbTick = slowTick;
      TB_DIV_FAST: tbTick = fastTick;
      TB_TMR_OVF:  tbTick = timerOvfPulse;
      TB_EXT_EDGE: tbTick = eciAccept;
      TB_SYSCLK:   tbTick = 1'b1;
      TB_OSC_DIV:  tbTick = oscTick;
      default:     tbTick = 1'b0;
    endcase
  end

  logic halted;
  assign halted = idleStop && cpuIdle;

  always_comb begin
    strobes.countEn   = runEn && !halted && tbTick;
    strobes.wrLow     = busWrEn && (busAddr == ADDR_LOW);
    strobes.wrHigh    = busWrEn && (busAddr == ADDR_HIGH);
    strobes.snapLoad  = busRdEn && (busAddr == ADDR_LOW);
    strobes.flagWr    = wrCtrl;
    strobes.flagWrVal = busWrData[7];
  end
endmodule

// File: rtl/tbc_datapath.sv
module tbc_datapath
  import tbc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [BYTE_W-1:0]   busWrData,
  output logic [2*BYTE_W-1:0] countValue,
  output logic [BYTE_W-1:0]   snapHigh,
  output logic                ovfFlag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic byteWrite, wrapNow;
  assign byteWrite = strobes.wrLow || strobes.wrHigh;
  assign wrapNow   = strobes.countEn && !byteWrite && (&countValue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countValue <= '0;
    end else if (strobes.wrLow) begin
      countValue[BYTE_W-1:0] <= busWrData;
    end else if (strobes.wrHigh) begin
      countValue[CNT_W-1:BYTE_W] <= busWrData;
    end else if (strobes.countEn) begin
      countValue <= countValue + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 snapHigh <= '0;
    else if (strobes.snapLoad) snapHigh <= countValue[CNT_W-1:BYTE_W];
  end

  // wrap beats a software clear
  always_ff @(posedge clk) begin
    if (!rstN) ovfFlag <= 1'b0;
    else       ovfFlag <= (strobes.flagWr ? (ovfFlag && strobes.flagWrVal) : ovfFlag) || wrapNow;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int OSC_DIV     = 8,
  parameter int ECI_GAP     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [BYTE_W-1:0]   busWrData,
  output logic [BYTE_W-1:0]   busRdData,
  input  logic                timerOvfPulse,
  input  logic                extCountIn,
  input  logic                extOscIn,
  input  logic                cpuIdle,
  input  logic                globalIntEn,
  input  logic                moduleIntEn,
  output logic [2*BYTE_W-1:0] countValue,
  output logic                ovfIrq
);
  ctlStrobes_t       strobes;
  logic [2:0]        modeSel;
  logic              idleStop, ovfIntEn, runEn, ovfFlag;
  logic [BYTE_W-1:0] snapHigh;

  tbc_ctrl #(
    .BYTE_W(BYTE_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
    .OSC_DIV(OSC_DIV), .ECI_GAP(ECI_GAP), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .timerOvfPulse(timerOvfPulse),
    .extCountIn(extCountIn), .extOscIn(extOscIn), .cpuIdle(cpuIdle),
    .strobes(strobes), .modeSel(modeSel), .idleStop(idleStop),
    .ovfIntEn(ovfIntEn), .runEn(runEn)
  );

  tbc_datapath #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .countValue(countValue), .snapHigh(snapHigh), .ovfFlag(ovfFlag)
  );

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_LOW:  busRdData = countValue[BYTE_W-1:0];
      ADDR_HIGH: busRdData = snapHigh;
      ADDR_MODE: begin
        busRdData[7]   = idleStop;
        busRdData[3:1] = modeSel;
        busRdData[0]   = ovfIntEn;
      end
      default: begin
        busRdData[7] = ovfFlag;
        busRdData[6] = runEn;
      end
    endcase
  end

  assign ovfIrq = ovfFlag && ovfIntEn && globalIntEn && moduleIntEn;
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  busAddr,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [15:0] countValue,
  input logic        ovfIrq,
  input logic        globalIntEn,
  input logic        moduleIntEn,
  input logic        ovfFlag,
  input logic        runEn,
  input logic [2:0]  modeSel,
  input logic        idleStop,
  input logic        cpuIdle
);
  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (globalIntEn && moduleIntEn && ovfFlag));

  // R9
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[2:1] == 2'b11 && !busWrEn) |=> $stable(countValue));

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !busWrEn) |=> $stable(countValue));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWrEn && busAddr == 2'd3)) |=> ovfFlag);

  // R11
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(countValue) == 16'hFFFF && countValue == 16'h0000 && !$past(busWrEn)) |-> ovfFlag);

  // R4
  read_no_disturb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && runEn && modeSel == 3'b100 && !(idleStop && cpuIdle))
      |=> countValue == 16'($past(countValue) + 16'd1));
endmodule

bind tbase_counter tbc_checker i_chk (.*);

// File: tb/test_tbase_counter.sv
module test_tbase_counter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic timerOvfPulse = 1'b0, extCountIn = 1'b1, extOscIn = 1'b0;
  logic cpuIdle = 1'b0, globalIntEn = 1'b0, moduleIntEn = 1'b0;
  logic [15:0] countValue;
  logic ovfIrq;

  always #(PERIOD/2) clk = ~clk;

  tbase_counter i_tbase_counter (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .timerOvfPulse(timerOvfPulse), .extCountIn(extCountIn), .extOscIn(extOscIn),
    .cpuIdle(cpuIdle), .globalIntEn(globalIntEn), .moduleIntEn(moduleIntEn),
    .countValue(countValue), .ovfIrq(ovfIrq)
  );

  int vectors = 0, errors = 0;
  string phase = "R1";

  // behavioural reference state
  int mCount, mSnap, mSel, p12, p4, oDiv, eHold;
  bit mFlag, mRun, mIdleStop, mIntEn;
  bit e1, e2, ePrev, o1, o2, oPrev;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRead();
    case (busAddr)
      2'd0: return mCount & 255;
      2'd1: return mSnap;
      2'd2: return (int'(mIdleStop) << 7) | (mSel << 1) | int'(mIntEn);
      default: return (int'(mFlag) << 7) | (int'(mRun) << 6);
    endcase
  endfunction

  task automatic modelStep();
    bit tick, adv, wrL, wrH, wrap, fall, acc, rise, oTick;
    if (!rstN) begin
      mCount = 0; mSnap = 0; mSel = 0; p12 = 0; p4 = 0; oDiv = 0; eHold = 0;
      mFlag = 0; mRun = 0; mIdleStop = 0; mIntEn = 0;
      e1 = 0; e2 = 0; ePrev = 0; o1 = 0; o2 = 0; oPrev = 0;
      return;
    end
    fall  = ePrev && !e2;
    acc   = fall && eHold == 0;
    rise  = o2 && !oPrev;
    oTick = rise && oDiv == 7;
    case (mSel)
      0: tick = (p12 == 11);
      1: tick = (p4 == 3);
      2: tick = timerOvfPulse;
      3: tick = acc;
      4: tick = 1;
      5: tick = oTick;
      default: tick = 0;
    endcase
    adv  = mRun && !(mIdleStop && cpuIdle) && tick;
    wrL  = busWrEn && busAddr == 0;
    wrH  = busWrEn && busAddr == 1;
    wrap = adv && !wrL && !wrH && mCount == 65535;
    if (busRdEn && busAddr == 0) mSnap = mCount >> 8;
    if (wrL)      mCount = (mCount & 16'hFF00) | busWrData;
    else if (wrH) mCount = (mCount & 255) | (int'(busWrData) << 8);
    else if (adv) mCount = (mCount + 1) % 65536;
    if (busWrEn && busAddr == 3) begin
      mFlag = mFlag && busWrData[7];
      mRun  = busWrData[6];
    end
    if (wrap) mFlag = 1;
    if (busWrEn && busAddr == 2) begin
      mIdleStop = busWrData[7]; mSel = busWrData[3:1]; mIntEn = busWrData[0];
    end
    p12 = (p12 + 1) % 12;
    p4  = (p4 + 1) % 4;
    if (acc) eHold = 3; else if (eHold > 0) eHold--;
    if (rise) oDiv = (oDiv + 1) % 8;
    ePrev = e2; e2 = e1; e1 = extCountIn;
    oPrev = o2; o2 = o1; o1 = extOscIn;
  endtask

  task automatic cycle();
    #1;
    if (rstN) check({phase, " busRdData"}, busRdData, expRead());
    @(posedge clk);
    modelStep();
    #2;
    check({phase, " countValue"}, countValue, mCount);
    check({phase, " ovfIrq"}, ovfIrq, mFlag && mIntEn && globalIntEn && moduleIntEn);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1; cycle(); busWrEn = 0;
  endtask

  task automatic readByte(logic [1:0] a, output logic [7:0] v);
    busAddr = a; busRdEn = 1; #1 v = busRdData; cycle(); busRdEn = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(4);
    rstN = 1;
    phase = "R1";
    check("R1 count after reset", countValue, 0);
    check("R1 irq after reset", ovfIrq, 0);
    readByte(2'd3, v); check("R1 ctrl reset", v, 0);
    readByte(2'd2, v); check("R1 mode reset", v, 0);

    phase = "R2";
    busWrite(2'd2, 8'h89);
    readByte(2'd2, v); check("R2 mode readback", v, 8'h89);
    busWrite(2'd2, 8'h08);

    phase = "R5";
    busWrite(2'd3, 8'h40);
    idle(20);
    busWrite(2'd2, 8'h00); idle(40);
    busWrite(2'd2, 8'h02); idle(20);

    phase = "R4";
    busWrite(2'd2, 8'h08);
    for (int i = 0; i < 10; i++) readByte(2'(i % 4), v);

    phase = "R3";
    busWrite(2'd3, 8'h00);
    busWrite(2'd0, 8'hFE);
    busWrite(2'd1, 8'h12);
    busWrite(2'd3, 8'h40);
    readByte(2'd0, v);
    idle(6);
    check("R3 live high moved", countValue[15:8], 8'h13);
    readByte(2'd1, v); check("R3 snapshot held", v, 8'h12);

    phase = "R13";
    busWrite(2'd0, 8'h55);
    check("R13 low write wins", countValue[7:0], 8'h55);
    busWrite(2'd1, 8'hA0);
    check("R13 high write wins", countValue, 16'hA055);

    phase = "R6";
    busWrite(2'd2, 8'h04);
    for (int i = 0; i < 8; i++) begin
      timerOvfPulse = (i % 3 != 0); cycle();
    end
    timerOvfPulse = 0; idle(3);

    phase = "R7";
    busWrite(2'd2, 8'h06);
    for (int i = 0; i < 6; i++) begin
      extCountIn = 0; idle(5); extCountIn = 1; idle(5);
    end
    for (int i = 0; i < 30; i++) begin
      extCountIn = ~extCountIn; cycle();
    end
    extCountIn = 1; idle(6);

    phase = "R8";
    busWrite(2'd2, 8'h0A);
    for (int i = 0; i < 80; i++) begin
      extOscIn = ~extOscIn; idle(2);
    end

    phase = "R9";
    busWrite(2'd2, 8'h0C); timerOvfPulse = 1; idle(10);
    busWrite(2'd2, 8'h0E); idle(10); timerOvfPulse = 0;
    for (int i = 0; i < 10; i++) begin extOscIn = ~extOscIn; cycle(); end

    phase = "R10";
    busWrite(2'd2, 8'h08); cpuIdle = 1; idle(8);
    busWrite(2'd2, 8'h88); idle(8); cpuIdle = 0; idle(4);
    busWrite(2'd3, 8'h00); idle(8);

    phase = "R11";
    busWrite(2'd2, 8'h09);
    busWrite(2'd0, 8'hF8);
    busWrite(2'd1, 8'hFF);
    busWrite(2'd3, 8'h40);
    idle(10);
    readByte(2'd3, v); check("R11 flag set after wrap", v, 8'hC0);
    busWrite(2'd3, 8'hC0);
    readByte(2'd3, v); check("R11 write one keeps flag", v, 8'hC0);
    busWrite(2'd3, 8'h40);
    readByte(2'd3, v); check("R11 write zero clears", v, 8'h40);
    busWrite(2'd2, 8'h05);
    busWrite(2'd0, 8'hFF);
    busWrite(2'd1, 8'hFF);
    timerOvfPulse = 1; busWrite(2'd3, 8'h40); timerOvfPulse = 0;
    check("R11 wrapped with clear", countValue, 0);
    readByte(2'd3, v); check("R11 overflow beats clear", v, 8'hC0);

    phase = "R12";
    check("R12 irq needs global", ovfIrq, 0);
    globalIntEn = 1; cycle(); check("R12 irq needs module", ovfIrq, 0);
    moduleIntEn = 1; cycle(); check("R12 irq all enabled", ovfIrq, 1);
    busWrite(2'd2, 8'h04); check("R12 irq local enable off", ovfIrq, 0);
    busWrite(2'd2, 8'h05); busWrite(2'd3, 8'h00);
    check("R12 irq after clear", ovfIrq, 0);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule